// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block works out the settings of a clock synthesizer whose output frequency is (M+2)·Fref / ((N+2)·2^R). It takes a target frequency in Hz and a set of limits (lowest VCO frequency, largest R, largest N, largest M). It first picks the post-divider exponent R that puts the VCO in its band. It then sweeps the input divider N, rounds the feedback value M for each N, and keeps the candidate whose rounded output frequency lies closest to the target. A last step flags any result that misses the target by 0.5 % or more. The reference frequency is a parameter, and all frequencies are unsigned 32-bit integers in Hz.

A search starts with a one-cycle `start` pulse while the engine is idle. `busy` stays high until the result is ready. `done` then pulses for one cycle and the results hold until a later search completes. The design is a state machine with these states:
- IDLE: on start, go to PICK_R.
- PICK_R: with no valid R or an empty N range, go to FINAL; otherwise go to LOAD_M.
- LOAD_M then DIV_M: divide for M.
- EVAL_M: if M fits, go to LOAD_F; otherwise go to NEXT_N.
- LOAD_F then DIV_F: divide for the achieved frequency.
- SCORE, then NEXT_N: at the last N, go to FINAL; otherwise go back to LOAD_M.
- FINAL, then IDLE.

Each division is done by a shared restoring divider that takes one quotient bit per cycle.

Top module: `pll_param_search`

## Requirements
- R1: After reset, `busy`, `done`, `bad`, `m_val`, `n_val`, `r_val` and `err_hz` are all zero.
- R2: A `start` seen while idle raises `busy` on the next cycle. `busy` stays high until the cycle in which `done` is high. In that cycle `busy` is low, and `done` lasts exactly one cycle.
- R3: `r_val` is the largest R in 0..`r_limit` for which `vco_min_hz` < target·2^R ≤ 2·`vco_min_hz`.
- R4: If no R meets R3, then `bad`=1 and `m_val`, `n_val`, `r_val` and `err_hz` are all 0.
- R5: N is swept from 1 to `n_limit`. For each N, q = floor((2·target·(N+2)·2^R + Fref) / (2·Fref)). The candidate is skipped when q<2 or when M = q−2 exceeds `m_limit`. If no candidate remains, then `bad`=1, `m_val`=`n_val`=`err_hz`=0, and `r_val` still reports R.
- R6: The achieved frequency is f = floor((2·(M+2)·Fref + D) / (2·D)) with D=(N+2)·2^R, and the candidate's error is |target − f|. The best error starts at target+1. A candidate replaces the best when its error is less than or equal to the best, so a later N wins a tie. `m_val`, `n_val` and `err_hz` report the winning candidate.
- R7: `bad` is 1 unless floor(0.995·target) < f < floor(1.005·target) for the winning f.
- R8: A `start` seen while `busy` is ignored. Inputs are captured only at an accepted start, so the result belongs to the first request.
- R9: The result outputs change only in a cycle where `done` is high. Otherwise they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search when idle |
| target_hz | input | 32 | Requested output frequency in Hz |
| vco_min_hz | input | 32 | Lower edge of the VCO band in Hz |
| r_limit | input | R_W | Largest allowed R |
| n_limit | input | N_W | Largest N of the sweep |
| m_limit | input | M_W | Largest allowed M |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| m_val | output | M_W | Chosen M |
| n_val | output | N_W | Chosen N |
| r_val | output | R_W | Chosen R |
| err_hz | output | 32 | Absolute error of the achieved frequency in Hz |
| bad | output | 1 | Out-of-range or out-of-tolerance flag |

## Verification
The latency of a search depends on the limits: each N costs about two divider passes of DIV_W cycles each, plus a few state cycles. For that reason the bench does not predict a fixed cycle count. It drives `start` on a falling edge, then watches every later falling edge. `busy` must stay high in each of those cycles until `done` appears. The results are compared in the same half-cycle as `done` and compared again one cycle later, when `done` must already be low. The R9 hold check reads the outputs twenty cycles after `done`, once the inputs have been changed. The R8 check issues a second start a few cycles into a search and still expects the first request's result.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    localparam int unsigned FREQ_W = 32;

    // tolerance band expressed as parts per thousand
    localparam int unsigned TOL_LO_PPT = 995;
    localparam int unsigned TOL_HI_PPT = 1005;
    localparam int unsigned TOL_SCALE  = 1000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PICK_R,
        ST_LOAD_M,
        ST_DIV_M,
        ST_EVAL_M,
        ST_LOAD_F,
        ST_DIV_F,
        ST_SCORE,
        ST_NEXT_N,
        ST_FINAL
    } srch_state_t;

endpackage

// File: rtl/pll_restoring_div.sv
module pll_restoring_div #(
    parameter int unsigned W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quot,
    output logic         fin
);
    localparam int unsigned CW = $clog2(W + 1);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  dsr_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [W:0]    trial;
    logic [W:0]    diff;
    logic          take;

    always_comb begin
        trial = {rem_q, quo_q[W-1]};
        diff  = trial - {1'b0, dsr_q};
        take  = (trial >= {1'b0, dsr_q});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dsr_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (ld) begin
                rem_q <= '0;
                quo_q <= dividend;
                dsr_q <= divisor;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= take ? diff[W-1:0] : trial[W-1:0];
                quo_q <= {quo_q[W-2:0], take};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    fin   <= 1'b1;
                end
            end
        end
    end

    assign quot = quo_q;

endmodule

// File: rtl/pll_vco_band.sv
module pll_vco_band
    import pll_search_pkg::*;
#(
    parameter int unsigned R_W = 2
) (
    input  logic [FREQ_W-1:0] tgt,
    input  logic [FREQ_W-1:0] vmin,
    input  logic [R_W-1:0]    rlim,
    output logic [R_W-1:0]    r_sel,
    output logic              hit
);
    localparam int unsigned R_CNT = 1 << R_W;
    localparam int unsigned SW    = FREQ_W + R_CNT;

    logic [SW-1:0] lo_edge;
    logic [SW-1:0] hi_edge;

    always_comb begin
        lo_edge = SW'(vmin);
        hi_edge = SW'(vmin) << 1;
        hit     = 1'b0;
        r_sel   = '0;
        // later (larger) R overrides an earlier match
        for (int i = 0; i < int'(R_CNT); i++) begin
            if ((i <= int'(rlim)) &&
                ((SW'(tgt) << i) > lo_edge) &&
                ((SW'(tgt) << i) <= hi_edge)) begin
                hit   = 1'b1;
                r_sel = R_W'(i);
            end
        end
    end

endmodule

// File: rtl/pll_param_search.sv
module pll_param_search
    import pll_search_pkg::*;
#(
    parameter logic [31:0] FREF_HZ = 32'd14318180,
    parameter int unsigned R_W     = 2,
    parameter int unsigned N_W     = 5,
    parameter int unsigned M_W     = 7,
    parameter int unsigned DIV_W   = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       target_hz,
    input  logic [31:0]       vco_min_hz,
    input  logic [R_W-1:0]    r_limit,
    input  logic [N_W-1:0]    n_limit,
    input  logic [M_W-1:0]    m_limit,
    output logic              busy,
    output logic              done,
    output logic [M_W-1:0]    m_val,
    output logic [N_W-1:0]    n_val,
    output logic [R_W-1:0]    r_val,
    output logic [31:0]       err_hz,
    output logic              bad
);
    localparam logic [DIV_W-1:0] FREF_W = DIV_W'(FREF_HZ);
    localparam int unsigned      EW     = FREQ_W + 1;

    srch_state_t state_q, state_d;

    logic [FREQ_W-1:0] tgt_q, vmin_q, best_f_q;
    logic [R_W-1:0]    rlim_q, r_q;
    logic [N_W-1:0]    nlim_q, n_q, best_n_q;
    logic [M_W-1:0]    mlim_q, mc_q, best_m_q;
    logic [EW-1:0]     best_err_q;
    logic              found_q, rok_q;

    logic [R_W-1:0]    r_pick;
    logic              r_hit;
    logic              div_ld, div_fin;
    logic [DIV_W-1:0]  div_num, div_den, div_q;
    logic [DIV_W-1:0]  n_plus2, den_f;
    logic              m_fit;
    logic [EW-1:0]     f_cand, cand_err;
    logic [DIV_W-1:0]  tgt_w, bf_w;
    logic              tol_ok;

    pll_vco_band #(.R_W(R_W)) u_band (
        .tgt   (tgt_q),
        .vmin  (vmin_q),
        .rlim  (rlim_q),
        .r_sel (r_pick),
        .hit   (r_hit)
    );

    pll_restoring_div #(.W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (div_ld),
        .dividend (div_num),
        .divisor  (div_den),
        .quot     (div_q),
        .fin      (div_fin)
    );

    // arithmetic feeding the divider and the scorer
    always_comb begin
        n_plus2 = DIV_W'(n_q) + DIV_W'(2);
        den_f   = n_plus2 << r_q;
        div_ld  = (state_q == ST_LOAD_M) || (state_q == ST_LOAD_F);
        if (state_q == ST_LOAD_F) begin
            div_num = (((DIV_W'(mc_q) + DIV_W'(2)) * FREF_W) << 1) + den_f;
            div_den = den_f << 1;
        end else begin
            div_num = (((DIV_W'(tgt_q) * n_plus2) << r_q) << 1) + FREF_W;
            div_den = FREF_W << 1;
        end
        m_fit    = (div_q >= DIV_W'(2)) && ((div_q - DIV_W'(2)) <= DIV_W'(mlim_q));
        f_cand   = EW'(div_q[FREQ_W-1:0]);
        cand_err = (EW'(tgt_q) >= f_cand) ? (EW'(tgt_q) - f_cand) : (f_cand - EW'(tgt_q));
        tgt_w    = DIV_W'(tgt_q);
        bf_w     = DIV_W'(best_f_q);
        tol_ok   = ((tgt_w * DIV_W'(TOL_LO_PPT)) < (bf_w * DIV_W'(TOL_SCALE))) &&
                   (((bf_w + DIV_W'(1)) * DIV_W'(TOL_SCALE)) <= (tgt_w * DIV_W'(TOL_HI_PPT)));
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_PICK_R;
            ST_PICK_R: state_d = (!r_hit || nlim_q == '0) ? ST_FINAL : ST_LOAD_M;
            ST_LOAD_M: state_d = ST_DIV_M;
            ST_DIV_M:  if (div_fin) state_d = ST_EVAL_M;
            ST_EVAL_M: state_d = m_fit ? ST_LOAD_F : ST_NEXT_N;
            ST_LOAD_F: state_d = ST_DIV_F;
            ST_DIV_F:  if (div_fin) state_d = ST_SCORE;
            ST_SCORE:  state_d = ST_NEXT_N;
            ST_NEXT_N: state_d = (n_q == nlim_q) ? ST_FINAL : ST_LOAD_M;
            ST_FINAL:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // search datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0; vmin_q <= '0; rlim_q <= '0; nlim_q <= '0; mlim_q <= '0;
            r_q <= '0; n_q <= '0; mc_q <= '0; rok_q <= 1'b0; found_q <= 1'b0;
            best_m_q <= '0; best_n_q <= '0; best_f_q <= '0; best_err_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    tgt_q      <= target_hz;
                    vmin_q     <= vco_min_hz;
                    rlim_q     <= r_limit;
                    nlim_q     <= n_limit;
                    mlim_q     <= m_limit;
                    n_q        <= N_W'(1);
                    found_q    <= 1'b0;
                    best_err_q <= EW'(target_hz) + EW'(1);
                end
                ST_PICK_R: begin
                    r_q   <= r_pick;
                    rok_q <= r_hit;
                end
                ST_EVAL_M: if (m_fit) mc_q <= M_W'(div_q - DIV_W'(2));
                ST_SCORE: if (cand_err <= best_err_q) begin
                    best_m_q   <= mc_q;
                    best_n_q   <= n_q;
                    best_f_q   <= f_cand[FREQ_W-1:0];
                    best_err_q <= cand_err;
                    found_q    <= 1'b1;
                end
                ST_NEXT_N: if (n_q != nlim_q) n_q <= n_q + N_W'(1);
                default: ;
            endcase
        end
    end

    // result outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0; bad <= 1'b0;
            m_val <= '0; n_val <= '0; r_val <= '0; err_hz <= '0;
        end else begin
            done <= (state_q == ST_FINAL);
            if (state_q == ST_FINAL) begin
                if (!rok_q) begin
                    m_val <= '0; n_val <= '0; r_val <= '0; err_hz <= '0; bad <= 1'b1;
                end else if (!found_q) begin
                    m_val <= '0; n_val <= '0; r_val <= r_q; err_hz <= '0; bad <= 1'b1;
                end else begin
                    m_val  <= best_m_q;
                    n_val  <= best_n_q;
                    r_val  <= r_q;
                    err_hz <= best_err_q[FREQ_W-1:0];
                    bad    <= !tol_ok;
                end
            end
        end
    end

    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/pll_param_search_chk.sv
module pll_param_search_chk #(
    parameter int unsigned R_W = 2,
    parameter int unsigned N_W = 5,
    parameter int unsigned M_W = 7
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [M_W-1:0] m_val,
    input logic [N_W-1:0] n_val,
    input logic [R_W-1:0] r_val,
    input logic [31:0]    err_hz,
    input logic           bad,
    input logic [31:0]    tgt_q,
    input logic [R_W-1:0] rlim_q,
    input logic [N_W-1:0] nlim_q,
    input logic [M_W-1:0] mlim_q
);
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R8
    busy_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(tgt_q));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({m_val, n_val, r_val, err_hz, bad}));

    // R3
    r_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !bad) |-> (r_val <= rlim_q));

    // R5
    mn_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !bad) |-> (m_val <= mlim_q && n_val != '0 && n_val <= nlim_q));

    // R7
    tol_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !bad) |-> (({16'd0, err_hz} * 48'd200) < {16'd0, tgt_q}));

endmodule

bind pll_param_search pll_param_search_chk #(.R_W(R_W), .N_W(N_W), .M_W(M_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .m_val  (m_val),
    .n_val  (n_val),
    .r_val  (r_val),
    .err_hz (err_hz),
    .bad    (bad),
    .tgt_q  (tgt_q),
    .rlim_q (rlim_q),
    .nlim_q (nlim_q),
    .mlim_q (mlim_q)
);

// File: tb/pll_param_search_tb.sv
module pll_param_search_tb;
    localparam longint unsigned FREF = 64'd14318180;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] target_hz = '0;
    logic [31:0] vco_min_hz = '0;
    logic [1:0]  r_limit = '0;
    logic [4:0]  n_limit = '0;
    logic [6:0]  m_limit = '0;
    logic        busy, done, bad;
    logic [6:0]  m_val;
    logic [4:0]  n_val;
    logic [1:0]  r_val;
    logic [31:0] err_hz;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pll_param_search u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .target_hz(target_hz),
        .vco_min_hz(vco_min_hz), .r_limit(r_limit), .n_limit(n_limit), .m_limit(m_limit),
        .busy(busy), .done(done), .m_val(m_val), .n_val(n_val), .r_val(r_val),
        .err_hz(err_hz), .bad(bad)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // arithmetic model built from the requirements
    task automatic model(input longint unsigned t, fmin, input int rmax, nmax, mmax,
                         output int em, en, er, output longint unsigned ee,
                         output bit ebad, output bit rfound);
        int rs;
        longint unsigned best, bf, q, den, f, d;
        bit found;
        rs = -1;
        for (int r = 0; r <= rmax; r++) begin
            f = t << r;
            if (fmin < f && f <= 2 * fmin) rs = r;
        end
        em = 0; en = 0; er = 0; ee = 0; ebad = 1; rfound = (rs >= 0);
        if (rs < 0) return;
        er = rs;
        best = t + 1; found = 0; bf = 0;
        for (int n = 1; n <= nmax; n++) begin
            q = ((2 * t * (n + 2)) << rs) + FREF;
            q = q / (2 * FREF);
            if (q < 2) continue;
            if (q - 2 > mmax) continue;
            den = longint'(n + 2) << rs;
            f = (2 * q * FREF + den) / (2 * den);
            d = (t >= f) ? t - f : f - t;
            if (d <= best) begin
                em = int'(q - 2); en = n; best = d; bf = f; found = 1;
            end
        end
        if (!found) return;
        ee = best;
        ebad = !((t * 995 < bf * 1000) && ((bf + 1) * 1000 <= t * 1005));
    endtask

    task automatic run_case(input longint unsigned t, fmin, input int rmax, nmax, mmax,
                            input bit retrigger);
        int em, en, er;
        longint unsigned ee;
        bit ebad, rf;
        bit busy_ok;
        string tr, tm, tn, te, tb;
        model(t, fmin, rmax, nmax, mmax, em, en, er, ee, ebad, rf);
        tr = rf ? "R3" : "R4";
        tm = rf ? "R5" : "R4";
        tn = rf ? "R6" : "R4";
        te = rf ? "R6" : "R4";
        tb = rf ? "R7" : "R4";
        @(negedge clk);
        target_hz = 32'(t); vco_min_hz = 32'(fmin);
        r_limit = 2'(rmax); n_limit = 5'(nmax); m_limit = 7'(mmax);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R2", "busy after start", longint'(busy), 1);
        busy_ok = 1'b1;
        for (int k = 0; !done; k++) begin
            if (retrigger && k == 5) begin
                // R8: a second request while busy must not take effect
                target_hz = 32'd50000000; r_limit = 2'd1; n_limit = 5'd3; m_limit = 7'd9;
                start = 1'b1;
            end else start = 1'b0;
            if (!busy) busy_ok = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        chk(busy_ok, "R2", "busy held through search", longint'(busy_ok), 1);
        chk(busy === 1'b0, "R2", "busy low with done", longint'(busy), 0);
        chk(r_val == 2'(er), retrigger ? "R8" : tr, "r_val", longint'(r_val), er);
        chk(m_val == 7'(em), retrigger ? "R8" : tm, "m_val", longint'(m_val), em);
        chk(n_val == 5'(en), retrigger ? "R8" : tn, "n_val", longint'(n_val), en);
        chk(err_hz == 32'(ee), retrigger ? "R8" : te, "err_hz", longint'(err_hz), longint'(ee));
        chk(bad == ebad, retrigger ? "R8" : tb, "bad", longint'(bad), longint'(ebad));
        @(negedge clk);
        chk(done === 1'b0, "R2", "done one cycle", longint'(done), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R2 watchdog: got %0d expected %0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done in reset", longint'({busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk({m_val, n_val, r_val, err_hz, bad} === '0, "R1", "outputs after reset",
            longint'(err_hz), 0);
        chk(busy === 1'b0, "R1", "idle after reset", longint'(busy), 0);

        // default limits: Fmin 135 MHz, Rmax 3, Nmax 31, Mmax 127
        run_case(25175000, 135000000, 3, 31, 127, 0);
        run_case(31500000, 135000000, 3, 31, 127, 0);
        run_case(40000000, 135000000, 3, 31, 127, 0);
        run_case(65000000, 135000000, 3, 31, 127, 0);
        run_case(108000000, 135000000, 3, 31, 127, 0);
        run_case(135000000, 135000000, 3, 31, 127, 0);
        run_case(200000000, 135000000, 3, 31, 127, 0);
        run_case(270000000, 135000000, 3, 31, 127, 0);
        run_case(270000001, 135000000, 3, 31, 127, 0); // R4: above band
        run_case(16875000, 135000000, 3, 31, 127, 0);  // R4: edge excluded
        run_case(10000000, 135000000, 3, 31, 127, 0);  // R4: below band

        // R5 corner: empty sweep and an M limit that rejects everything
        run_case(40000000, 135000000, 3, 0, 127, 0);
        run_case(40000000, 135000000, 3, 5, 3, 0);

        // R8: retrigger during a search
        run_case(65000000, 135000000, 3, 31, 127, 1);

        // R9: outputs hold while inputs move and no search runs
        begin
            logic [46:0] snap;
            snap = {m_val, n_val, r_val, err_hz, bad};
            target_hz = 32'd77777777; n_limit = 5'd2;
            repeat (20) @(negedge clk);
            chk({m_val, n_val, r_val, err_hz, bad} == snap, "R9", "hold after done",
                longint'({m_val, n_val, r_val, err_hz, bad}), longint'(snap));
        end

        // sweep over a small configuration: all R limits, short N range
        for (int rl = 0; rl < 4; rl++) begin
            for (int k = 0; k < 8; k++) begin
                run_case(longint'(20000000 + k * 17300000), 90000000, rl, 7, 60, 0);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule